// File: doc/BRIEF.md
# MDIO Management Command Engine

This block lets software run one Clause 22 management transaction at a time against an external PHY. Software reaches it through a plain 32-bit register write and registered read port. To issue a write, software first loads the 16-bit value into the low half of the data register. It then writes a command word that carries a go bit, one operation bit, the PHY address and the register number. The engine serialises a complete management frame on MDC/MDIO and holds a busy flag in the command register until the last bit has been clocked.

For a read, the engine stops driving MDIO at the turnaround and samples the PHY's reply on rising MDC. It places the 16-bit result in the upper half of the data register. A PHY that fails to pull the second turnaround bit low marks the read as unanswered in a status register. In that case the previously captured data is left in place. MDC only toggles while a frame is in flight, and its half period is a parameter counted in system clocks.

Top module: `mdio_cmd_ctrl`

## Requirements
- R1: After reset, the command register (offset 0x3C0), data register (0x3C4) and status register (0x3D0) all read 0. MDC is low, MDIO-out-enable is low and MDIO-out is high.
- R2: A write to the command register is accepted when busy is clear, bit 20 is 1 and exactly one of bit 17 (read) or bit 16 (write) is 1. The PHY address is taken from bits 12:8 and the register number from bits 4:0. Bit 20 reads 1 from the first register read after the accepting edge, and it stays 1 for exactly 128*MDC_HALF consecutive clock cycles. Afterwards the command register reads back the accepted operation bit, PHY address and register number.
- R3: MDC has a period of 2*MDC_HALF clock cycles while a frame runs. A frame contains exactly 64 rising MDC edges. MDC rests low when idle.
- R4: A write frame sends, MSB first on each field, 32 ones, start 01, opcode 01, the 5-bit PHY address, the 5-bit register number, turnaround 10 and bits 15:0 of the data register. MDIO-out-enable is high for all 64 bits.
- R5: A read frame sends 32 ones, start 01, opcode 10, the PHY address and the register number. It then drops MDIO-out-enable for the two turnaround bits and the 16 data bits.
- R6: The 16 bits that MDIO-in carries on rising MDC during the data phase of a read land in bits 31:16 of the data register, MSB first. Bits 15:0 are not changed. A data-register write loads all 32 bits.
- R7: Status bit 0 becomes 1 when a read completes with MDIO-in high on the second turnaround bit, and bits 31:16 of the data register then keep their old value. A read that sees that bit low clears status bit 0. Write frames leave the status unchanged.
- R8: A command written while busy is 1 is ignored. No extra frame is sent, and the command fields read back are those of the running transaction.
- R9: A command word with bit 20 clear, or with both or neither of bits 17 and 16 set, is ignored. Busy stays 0 and no frame is sent.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | ADDR_W | Register byte offset for reads and writes |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Registered read data for the offset presented one cycle earlier |
| mdc | output | 1 | Management clock to the PHY |
| mdio_o | output | 1 | Serial data driven toward the PHY |
| mdio_oe | output | 1 | Drive enable for mdio_o |
| mdio_i | input | 1 | Serial data received from the PHY |

## Verification
A command is accepted on the edge that captures the register write. Busy is then visible on the read data one cycle later and stays set for exactly 128*MDC_HALF cycles, because each of the 64 bits takes two MDC half periods counted from that edge. The bench presents the command offset and samples reg_rdata at every falling system-clock edge, and it requires exactly that many busy samples. A PHY model in the bench changes MDIO-in on falling MDC and captures MDIO-out on rising MDC. Each frame ending at its 64th rising edge is popped against the expected frame queued by the issuing task. Data and status values are read only after busy has been seen clear, so they reflect the completing edge.

// File: rtl/mdio_pkg.sv
package mdio_pkg;

  localparam logic [11:0] OFS_CMD  = 12'h3C0;
  localparam logic [11:0] OFS_DATA = 12'h3C4;
  localparam logic [11:0] OFS_STAT = 12'h3D0;

  localparam int BIT_BUSY = 20;
  localparam int BIT_RD   = 17;
  localparam int BIT_WR   = 16;
  localparam int PHY_LSB  = 8;

  localparam int FRAME_LEN  = 64;
  localparam int TA_FIRST   = 46;
  localparam int DATA_FIRST = 48;

  typedef struct packed {
    logic       rd;
    logic [4:0] phy;
    logic [4:0] regn;
  } mdio_cmd_t;

  function automatic logic [FRAME_LEN-1:0] build_frame(input mdio_cmd_t c,
                                                      input logic [15:0] wv);
    logic [FRAME_LEN-1:0] f;
    f = {32'hFFFF_FFFF, 2'b01, (c.rd ? 2'b10 : 2'b01), c.phy, c.regn,
         (c.rd ? 2'b11 : 2'b10), (c.rd ? 16'hFFFF : wv)};
    return f;
  endfunction

endpackage

// File: rtl/mdc_clkgen.sv
module mdc_clkgen #(
  parameter int HALF_DIV = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic en,
  output logic mdc,
  output logic rise,
  output logic fall
);
  localparam int CW = $clog2(HALF_DIV + 1);
  localparam logic [CW-1:0] TERM = CW'(HALF_DIV - 1);

  logic [CW-1:0] cnt;
  logic          wrap;

  assign wrap = en && (cnt == TERM);
  assign rise = wrap && !mdc;
  assign fall = wrap && mdc;

  always_ff @(posedge clk) begin
    if (rst || !en) begin
      cnt <= '0;
      mdc <= 1'b0;
    end else if (cnt == TERM) begin
      cnt <= '0;
      mdc <= ~mdc;
    end else begin
      cnt <= cnt + 1'b1;
    end
  end

  // R3: the management clock rests low whenever no frame is running
  a_r3_idle_low: assert property (@(posedge clk) disable iff (rst)
    !en |=> !mdc);

endmodule

// File: rtl/mdio_frame_engine.sv
module mdio_frame_engine
  import mdio_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        start,
  input  mdio_cmd_t   cmd_in,
  input  logic [15:0] wr_word,
  input  logic        rise,
  input  logic        fall,
  input  logic        mdio_i,
  output logic        run,
  output logic        mdio_o,
  output logic        mdio_oe,
  output logic        done,
  output logic        done_rd,
  output logic        ta_low,
  output logic [15:0] rd_word
);
  localparam int IW = $clog2(FRAME_LEN);
  localparam logic [IW-1:0] LAST_IDX  = IW'(FRAME_LEN - 1);
  localparam logic [IW-1:0] TA2_IDX   = IW'(TA_FIRST + 1);
  localparam logic [IW-1:0] DATA_IDX  = IW'(DATA_FIRST);
  localparam logic [IW-1:0] DRIVE_END = IW'(TA_FIRST - 1);

  logic [FRAME_LEN-1:0] new_frame;
  logic [FRAME_LEN-2:0] shreg;
  logic [IW-1:0]        idx;
  logic                 is_rd;

  assign new_frame = build_frame(cmd_in, wr_word);

  always_ff @(posedge clk) begin
    if (rst) begin
      run     <= 1'b0;
      mdio_o  <= 1'b1;
      mdio_oe <= 1'b0;
      done    <= 1'b0;
      done_rd <= 1'b0;
      ta_low  <= 1'b0;
      rd_word <= '0;
      shreg   <= '0;
      idx     <= '0;
      is_rd   <= 1'b0;
    end else begin
      done    <= 1'b0;
      done_rd <= 1'b0;
      if (!run) begin
        if (start) begin
          run     <= 1'b1;
          idx     <= '0;
          is_rd   <= cmd_in.rd;
          ta_low  <= 1'b0;
          mdio_o  <= new_frame[FRAME_LEN-1];
          shreg   <= new_frame[FRAME_LEN-2:0];
          mdio_oe <= 1'b1;
        end
      end else begin
        if (rise && is_rd) begin
          if (idx == TA2_IDX) ta_low <= !mdio_i;
          if (idx >= DATA_IDX) rd_word <= {rd_word[14:0], mdio_i};
        end
        if (fall) begin
          if (idx == LAST_IDX) begin
            run     <= 1'b0;
            mdio_oe <= 1'b0;
            mdio_o  <= 1'b1;
            done    <= 1'b1;
            done_rd <= is_rd;
          end else begin
            idx     <= idx + 1'b1;
            mdio_o  <= shreg[FRAME_LEN-2];
            shreg   <= {shreg[FRAME_LEN-3:0], 1'b1};
            mdio_oe <= !is_rd || (idx < DRIVE_END);
          end
        end
      end
    end
  end

  // R5: a read never drives the line during turnaround or data
  a_r5_read_release: assert property (@(posedge clk) disable iff (rst)
    (run && is_rd && idx >= IW'(TA_FIRST)) |-> !mdio_oe);

  // R4: a write drives the line for the whole frame
  a_r4_write_drive: assert property (@(posedge clk) disable iff (rst)
    (run && !is_rd) |-> mdio_oe);

  // R3: the frame ends only on a falling management clock edge
  a_r3_end_on_fall: assert property (@(posedge clk) disable iff (rst)
    (run && !fall) |=> run);

endmodule

// File: rtl/mdio_cmd_ctrl.sv
module mdio_cmd_ctrl
  import mdio_pkg::*;
#(
  parameter int MDC_HALF = 4,
  parameter int ADDR_W   = 12
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reg_we,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  output logic              mdc,
  output logic              mdio_o,
  output logic              mdio_oe,
  input  logic              mdio_i
);
  localparam logic [ADDR_W-1:0] A_CMD  = ADDR_W'(OFS_CMD);
  localparam logic [ADDR_W-1:0] A_DATA = ADDR_W'(OFS_DATA);
  localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(OFS_STAT);

  logic        busy, eng_done, eng_done_rd, eng_ta_low;
  logic [15:0] eng_word;
  logic        mdc_rise, mdc_fall;
  logic        cmd_sel, accept;
  mdio_cmd_t   cmd_new, cmd_q;
  logic        cmd_valid_q;
  logic [31:0] data_q;
  logic        stat_bad;

  assign cmd_sel = reg_we && (reg_addr == A_CMD);
  assign accept  = cmd_sel && !busy && reg_wdata[BIT_BUSY] &&
                   (reg_wdata[BIT_RD] ^ reg_wdata[BIT_WR]);
  assign cmd_new = '{rd:   reg_wdata[BIT_RD],
                     phy:  reg_wdata[PHY_LSB+4:PHY_LSB],
                     regn: reg_wdata[4:0]};

  mdc_clkgen #(.HALF_DIV(MDC_HALF)) u_clkgen (
    .clk  (clk),
    .rst  (rst),
    .en   (busy),
    .mdc  (mdc),
    .rise (mdc_rise),
    .fall (mdc_fall)
  );

  mdio_frame_engine u_engine (
    .clk     (clk),
    .rst     (rst),
    .start   (accept),
    .cmd_in  (cmd_new),
    .wr_word (data_q[15:0]),
    .rise    (mdc_rise),
    .fall    (mdc_fall),
    .mdio_i  (mdio_i),
    .run     (busy),
    .mdio_o  (mdio_o),
    .mdio_oe (mdio_oe),
    .done    (eng_done),
    .done_rd (eng_done_rd),
    .ta_low  (eng_ta_low),
    .rd_word (eng_word)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      cmd_q       <= '0;
      cmd_valid_q <= 1'b0;
      data_q      <= '0;
      stat_bad    <= 1'b0;
    end else begin
      if (accept) begin
        cmd_q       <= cmd_new;
        cmd_valid_q <= 1'b1;
      end
      if (reg_we && reg_addr == A_DATA) data_q <= reg_wdata;
      if (eng_done_rd) begin
        if (eng_ta_low) begin
          data_q[31:16] <= eng_word;
          stat_bad      <= 1'b0;
        end else begin
          stat_bad      <= 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      reg_rdata <= '0;
    end else begin
      reg_rdata <= '0;
      if (reg_addr == A_CMD) begin
        reg_rdata[BIT_BUSY]            <= busy;
        reg_rdata[BIT_RD]              <= cmd_valid_q && cmd_q.rd;
        reg_rdata[BIT_WR]              <= cmd_valid_q && !cmd_q.rd;
        reg_rdata[PHY_LSB+4:PHY_LSB]   <= cmd_q.phy;
        reg_rdata[4:0]                 <= cmd_q.regn;
      end else if (reg_addr == A_DATA) begin
        reg_rdata <= data_q;
      end else if (reg_addr == A_STAT) begin
        reg_rdata[0] <= stat_bad;
      end
    end
  end

  // R2: an accepted command makes the engine busy on the next cycle
  a_r2_busy_after_accept: assert property (@(posedge clk) disable iff (rst)
    accept |=> busy);

  // R8: command fields cannot change while a transaction runs
  a_r8_ignore_busy: assert property (@(posedge clk) disable iff (rst)
    (busy && cmd_sel) |=> $stable(cmd_q));

  // R9: a command without the go bit never starts a frame
  a_r9_no_go: assert property (@(posedge clk) disable iff (rst)
    (!busy && cmd_sel && !reg_wdata[BIT_BUSY]) |=> !busy);

  // R7: status only moves when a read completes
  a_r7_stat_hold: assert property (@(posedge clk) disable iff (rst)
    !eng_done_rd |=> $stable(stat_bad));

endmodule

// File: tb/mdio_cmd_ctrl_tb.sv
module mdio_cmd_ctrl_tb;
  localparam int H = 4;
  localparam int BUSY_CYC = 128 * H;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        reg_we = 1'b0;
  logic [11:0] reg_addr = 12'h0;
  logic [31:0] reg_wdata = 32'h0;
  logic [31:0] reg_rdata;
  logic        mdc, mdio_o, mdio_oe;
  logic        mdio_i = 1'b1;

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;

  always #10 clk = ~clk;
  always @(posedge clk) cyc++;

  mdio_cmd_ctrl #(.MDC_HALF(H), .ADDR_W(12)) u_dut (
    .clk(clk), .rst(rst), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .mdc(mdc),
    .mdio_o(mdio_o), .mdio_oe(mdio_oe), .mdio_i(mdio_i)
  );

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // scoreboard of expected frames
  typedef struct {
    logic [63:0] frame;
    logic        rd;
  } exp_t;
  exp_t q[$];

  int          bitn = 0;
  int          frames = 0;
  int          last_rise = 0;
  logic        period_bad = 1'b0;
  logic [63:0] rx = '0;
  logic [63:0] rx_oe = '0;
  logic        phy_answer = 1'b1;
  logic [15:0] phy_data = 16'h0;

  function automatic logic [63:0] mk_frame(input logic rd, input logic [4:0] phy,
                                            input logic [4:0] rg, input logic [15:0] d);
    return {32'hFFFF_FFFF, 2'b01, (rd ? 2'b10 : 2'b01), phy, rg,
            (rd ? 2'b00 : 2'b10), (rd ? 16'h0 : d)};
  endfunction

  // PHY model and monitor: capture on rising MDC
  always @(posedge mdc) begin
    if (bitn > 0 && (cyc - last_rise) != 2 * H) period_bad = 1'b1;
    last_rise = cyc;
    if (bitn < 64) begin
      rx[63 - bitn]    = mdio_o;
      rx_oe[63 - bitn] = mdio_oe;
    end
    bitn++;
    if (bitn == 64) begin
      exp_t e;
      frames++;
      if (q.size() == 0) begin
        checks++; fails++;
        $display("FAIL R8 actual=unexpected frame expected=no frame");
      end else begin
        e = q.pop_front();
        if (e.rd) begin
          check("R5 read header", {18'h0, rx[63:18]}, {18'h0, e.frame[63:18]});
          check("R5 read oe", rx_oe, {46'h3FFF_FFFF_FFFF, 18'h0});
        end else begin
          check("R4 write frame", rx, e.frame);
          check("R4 write oe", rx_oe, 64'hFFFF_FFFF_FFFF_FFFF);
        end
        check("R3 mdc period", {63'h0, period_bad}, 64'h0);
      end
    end
  end

  // PHY model: change MDIO-in on falling MDC
  always @(negedge mdc) begin
    logic is_rd;
    is_rd = (rx[63-34] == 1'b1) && (rx[63-35] == 1'b0);
    if (is_rd && phy_answer && bitn == 47)
      mdio_i = 1'b0;
    else if (is_rd && phy_answer && bitn >= 48 && bitn <= 63)
      mdio_i = phy_data[63 - bitn];
    else
      mdio_i = 1'b1;
  end

  task automatic reg_wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic reg_rd(input logic [11:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_addr = a;
    @(negedge clk);
    d = reg_rdata;
  endtask

  task automatic wait_idle(output int n);
    n = 0;
    reg_addr = 12'h3C0;
    forever begin
      @(negedge clk);
      if (reg_rdata[20]) n++;
      else break;
    end
  endtask

  task automatic issue(input logic rd, input logic [4:0] phy, input logic [4:0] rg,
                       input logic [15:0] d);
    exp_t e;
    e.frame = mk_frame(rd, phy, rg, d);
    e.rd = rd;
    q.push_back(e);
    bitn = 0; period_bad = 1'b0; rx = '0; rx_oe = '0;
    reg_wr(12'h3C0, 32'h0010_0000 | (rd ? 32'h0002_0000 : 32'h0001_0000) |
                    ({27'h0, phy} << 8) | {27'h0, rg});
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog actual=timeout expected=completion");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    logic [31:0] r;
    int n, f0;
    repeat (3) @(negedge clk);
    rst = 1'b0;

    // R1 reset state
    reg_rd(12'h3C0, r); check("R1 cmd", {32'h0, r}, 64'h0);
    reg_rd(12'h3C4, r); check("R1 data", {32'h0, r}, 64'h0);
    reg_rd(12'h3D0, r); check("R1 stat", {32'h0, r}, 64'h0);
    check("R1 pins", {61'h0, mdc, mdio_oe, mdio_o}, 64'h1);

    // R2/R4 write transaction
    reg_wr(12'h3C4, 32'h0000_A5C3);
    issue(1'b0, 5'd5, 5'h1B, 16'hA5C3);
    wait_idle(n);
    check("R2 busy length", 64'(n), 64'(BUSY_CYC));
    reg_rd(12'h3C0, r);
    check("R2 cmd readback", {32'h0, r}, 64'h0001_051B);
    check("R3 idle pins", {62'h0, mdc, mdio_oe}, 64'h0);
    check("R3 64 rises", 64'(bitn), 64'd64);

    // R5/R6 answered read
    phy_answer = 1'b1; phy_data = 16'h3C5A;
    issue(1'b1, 5'h1F, 5'h02, 16'h0);
    wait_idle(n);
    check("R2 busy length read", 64'(n), 64'(BUSY_CYC));
    reg_rd(12'h3C4, r); check("R6 data", {32'h0, r}, 64'h3C5A_A5C3);
    reg_rd(12'h3D0, r); check("R7 valid stat", {32'h0, r}, 64'h0);

    // R7 unanswered read
    phy_answer = 1'b0;
    issue(1'b1, 5'd3, 5'd4, 16'h0);
    wait_idle(n);
    reg_rd(12'h3D0, r); check("R7 invalid stat", {32'h0, r}, 64'h1);
    reg_rd(12'h3C4, r); check("R7 data kept", {32'h0, r}, 64'h3C5A_A5C3);

    // R7 write leaves status
    reg_wr(12'h3C4, 32'h0000_0000);
    issue(1'b0, 5'h1F, 5'h1F, 16'h0000);
    wait_idle(n);
    reg_rd(12'h3D0, r); check("R7 write keeps stat", {32'h0, r}, 64'h1);

    // R6/R7 answered read clears status
    phy_answer = 1'b1; phy_data = 16'h8001;
    issue(1'b1, 5'd0, 5'h1F, 16'h0);
    wait_idle(n);
    reg_rd(12'h3D0, r); check("R7 cleared", {32'h0, r}, 64'h0);
    reg_rd(12'h3C4, r); check("R6 data 2", {32'h0, r}, 64'h8001_0000);

    // R9 malformed commands
    f0 = frames;
    reg_wr(12'h3C0, 32'h0013_0102);
    reg_rd(12'h3C0, r); check("R9 both ops busy", {63'h0, r[20]}, 64'h0);
    reg_wr(12'h3C0, 32'h0002_0102);
    reg_rd(12'h3C0, r); check("R9 no go busy", {63'h0, r[20]}, 64'h0);
    reg_wr(12'h3C0, 32'h0010_0102);
    repeat (4 * H) @(negedge clk);
    reg_rd(12'h3C0, r); check("R9 no op busy", {63'h0, r[20]}, 64'h0);
    check("R9 no frame", 64'(frames), 64'(f0));

    // R8 command while busy
    reg_wr(12'h3C4, 32'h0000_1234);
    f0 = frames;
    issue(1'b0, 5'd1, 5'd3, 16'h1234);
    repeat (100) @(negedge clk);
    reg_wr(12'h3C0, 32'h0012_0907);
    wait_idle(n);
    reg_rd(12'h3C0, r); check("R8 fields kept", {32'h0, r}, 64'h0001_0103);
    repeat (20 * H) @(negedge clk);
    check("R8 one frame", 64'(frames), 64'(f0 + 1));
    check("R8 queue empty", 64'(q.size()), 64'h0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule